// File: doc/BRIEF.md
# Burst Column Address Generator

This block steps the column address through the beats of a DRAM burst. A start pulse loads a starting column together with a burst-length code and an ordering choice. The block then presents one column per beat until the burst ends or is cut off. The row address is handled elsewhere and stays fixed for the whole burst. This block only walks the column.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside an aligned block whose size equals the burst length. In sequential order the column counts up and wraps to the bottom of that block. In interleaved order, beat i presents the start column XOR i on the bits inside the block. A full-column burst counts up modulo 2^COL_W and runs until it is terminated.

The beat stream is valid/ready. `valid_o` marks the presented beat, and `adv_i` acts as ready. A beat is consumed only in a cycle where both are high. While `adv_i` is low, the column and the flags hold. `adv_i` has no effect while `valid_o` is low. Masked data beats still advance, because the data path consumes them with `adv_i` like any other beat.

Top module: `bcg_burst_col_gen`

## Requirements
- R1: On the clock edge that samples `start_i`, the block loads `start_col_i`, `len_code_i` and `order_i`. After that edge `valid_o` is 1 and `col_o` equals the sampled start column.
- R2: The length code sets the burst length: 3'b000 gives 1 beat, 3'b001 gives 2 beats, 3'b010 gives 4 beats, 3'b011 gives 8 beats, and any code with bit 2 set gives a full-column burst.
- R3: In sequential order (`order_i`=0), every consumed beat adds 1 to the low bits inside the aligned block and wraps to the lowest column of the block. Column bits above the block always equal the start column's bits.
- R4: In interleaved order (`order_i`=1) with a length of 2, 4 or 8, beat i presents start XOR i on the low log2(length) bits. The column therefore alternates between even and odd. For a length of 1 or a full-column burst, the order input has no effect and the burst runs sequentially.
- R5: A beat is consumed only when `valid_o` and `adv_i` are both high. When `adv_i` is low, `col_o`, `valid_o` and `last_o` hold their values. `adv_i` while idle has no effect.
- R6: `last_o` is 1 exactly on the final beat of a fixed-length burst. Consuming that beat drops `valid_o` on the next edge.
- R7: A full-column burst wraps modulo 2^COL_W, never raises `last_o`, and stays valid until it is terminated or restarted.
- R8: `term_i` drops `valid_o` and `last_o` on the next edge. If `start_i` is high in the same cycle, the start takes priority.
- R9: A start during an active burst cuts that burst off and begins the new burst from beat 0.
- R10: After reset, and whenever `valid_o` is low, `col_o` and `last_o` read 0.
- R11: Changes on `len_code_i`, `order_i` and `start_col_i` outside a start cycle do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a burst (pulse) |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| term_i | input | 1 | Cut off the running burst |
| adv_i | input | 1 | Beat consumed (ready) |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Sequential bursts start at unaligned columns near the top of their block. This separates wrapping inside the block from carrying into the upper bits. Interleaved bursts from odd starts expose an adder used where an XOR is required, because the two orderings differ from the second beat on. A full-column burst that crosses 0xFF shows the modulo wrap and confirms that `last_o` never rises. Random traffic with back-pressure gaps, terminations, restarts and mode changes during a burst shows whether beats are lost or duplicated under stalls, and whether the mode is sampled only on a start.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int LEN_CODE_W = 3;

  typedef enum logic {
    ORD_SEQ  = 1'b0,
    ORD_INTL = 1'b1
  } order_e;

  localparam logic [LEN_CODE_W-1:0] LEN_1 = 3'b000;
  localparam logic [LEN_CODE_W-1:0] LEN_2 = 3'b001;
  localparam logic [LEN_CODE_W-1:0] LEN_4 = 3'b010;
  localparam logic [LEN_CODE_W-1:0] LEN_8 = 3'b011;
  localparam logic [LEN_CODE_W-1:0] LEN_FULL = 3'b100;
endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  order_e                order,
  output logic [COL_W-1:0]      mask,
  output logic                  full,
  output logic                  intl
);
  always_comb begin
    full = len_code[LEN_CODE_W-1];
    if (full) mask = '1;
    else      mask = COL_W'((32'd1 << len_code[1:0]) - 32'd1);
    intl = (order == ORD_INTL) && !full && (len_code[1:0] != 2'd0);
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             term,
  input  logic             adv,
  input  logic [COL_W-1:0] mask,
  input  logic             full,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic             last
);
  assign last = active && !full && (beat == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (load) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (term) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (adv && active) begin
      if (last) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  // R8: termination without a start empties the burst
  a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !load) |=> !active);
  // R6: consuming the final beat ends the burst
  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (last && adv && !load && !term) |=> !active);
  // R9: a start always begins at beat 0
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && beat == '0));
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             intl,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_sum;

  always_comb begin
    seq_sum = start_col + beat;
    if (intl) col = start_col ^ (beat & mask);
    else      col = (start_col & ~mask) | (seq_sum & mask);
  end
endmodule

// File: rtl/bcg_burst_col_gen.sv
module bcg_burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  input  logic                  term_i,
  input  logic                  adv_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);
  logic [COL_W-1:0]      start_q;
  logic [LEN_CODE_W-1:0] len_q;
  order_e                ord_q;
  logic [COL_W-1:0]      mask;
  logic                  full;
  logic                  intl;
  logic                  active;
  logic [COL_W-1:0]      beat;
  logic                  last;
  logic [COL_W-1:0]      col_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      ord_q   <= ORD_SEQ;
    end else if (start_i) begin
      start_q <= start_col_i;
      len_q   <= len_code_i;
      ord_q   <= order_e'(order_i);
    end
  end

  bcg_mode_decode #(.COL_W(COL_W)) u_dec (
    .len_code(len_q), .order(ord_q), .mask(mask), .full(full), .intl(intl)
  );

  bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_i), .term(term_i), .adv(adv_i),
    .mask(mask), .full(full), .active(active), .beat(beat), .last(last)
  );

  bcg_col_map #(.COL_W(COL_W)) u_map (
    .start_col(start_q), .beat(beat), .mask(mask), .intl(intl), .col(col_raw)
  );

  assign valid_o = active;
  assign last_o  = last;
  assign col_o   = active ? col_raw : '0;

  // R1: the first beat shows the sampled start column
  a_r1_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));
  // R3: the bits above the aligned block never move
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((col_o & ~mask) == (start_q & ~mask)));
  // R4: interleaved steps flip the column parity
  a_r4_intl_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && !last_o && !start_i && !term_i && intl)
      |=> (col_o[0] != $past(col_o[0])));
  // R5: a stall holds the presented beat
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !adv_i && !start_i && !term_i)
      |=> (valid_o && $stable(col_o) && $stable(last_o)));
endmodule

// File: tb/tb_bcg_burst_col_gen.sv
module tb_bcg_burst_col_gen;
  localparam int COL_W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic order_i = 1'b0;
  logic term_i = 1'b0;
  logic adv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference state
  bit m_act = 1'b0;
  logic [COL_W-1:0] m_s = '0, m_b = '0;
  logic [2:0] m_lc = '0;
  bit m_io = 1'b0;

  bcg_burst_col_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .order_i(order_i), .term_i(term_i), .adv_i(adv_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [COL_W-1:0] len_mask(input logic [2:0] lc);
    if (lc[2]) return '1;
    return COL_W'((1 << lc[1:0]) - 1);
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input logic [2:0] lc, input bit io, input logic [COL_W-1:0] b);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] sum;
    m = len_mask(lc);
    sum = s + b;
    if (io && !lc[2] && lc[1:0] != 2'd0) return s ^ (b & m);
    return (s & ~m) | (sum & m);
  endfunction

  function automatic bit exp_last();
    return m_act && !m_lc[2] && (m_b == len_mask(m_lc));
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    check(tag, "valid", 32'(valid_o), 32'(m_act));
    check(tag, "col", 32'(col_o), m_act ? 32'(exp_col(m_s, m_lc, m_io, m_b)) : 32'd0);
    check(tag, "last", 32'(last_o), 32'(exp_last()));
  endtask

  // one clock: drive at negedge, advance model, compare after the edge
  task automatic step(input bit st, input logic [COL_W-1:0] sc, input logic [2:0] lc,
                      input bit io, input bit tm, input bit ad, input string tag);
    bit lst;
    @(negedge clk);
    start_i = st; start_col_i = sc; len_code_i = lc; order_i = io;
    term_i = tm; adv_i = ad;
    lst = exp_last();
    if (st) begin
      m_act = 1'b1; m_s = sc; m_lc = lc; m_io = io; m_b = '0;
    end else if (tm) begin
      m_act = 1'b0; m_b = '0;
    end else if (ad && m_act) begin
      if (lst) begin m_act = 1'b0; m_b = '0; end
      else m_b = m_b + 1'b1;
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic idle(input bit ad, input string tag);
    step(1'b0, $urandom_range(0, 255), $urandom_range(0, 7), $urandom_range(0, 1), 1'b0, ad, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    vectors++; // R10 reset state
    check("R10", "valid", 32'(valid_o), 0);
    check("R10", "col", 32'(col_o), 0);
    check("R10", "last", 32'(last_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R5: advance while idle does nothing
    idle(1'b1, "R5");
    // R3 R6: sequential, length 4, start 0x2E -> 2E 2F 2C 2D
    step(1, 8'h2E, 3'b010, 0, 0, 0, "R1");
    for (int i = 0; i < 4; i++) idle(1'b1, "R3");
    // R4: interleaved, length 8, odd start
    step(1, 8'h45, 3'b011, 1, 0, 0, "R4");
    idle(1'b1, "R4");
    vectors++; check("R4", "col beat1", 32'(col_o), 32'h44);
    idle(1'b1, "R4");
    vectors++; check("R4", "col beat2", 32'(col_o), 32'h47);
    for (int i = 0; i < 6; i++) idle(1'b1, "R6");
    // R2 R4: length 1 with interleaved request is a single beat
    step(1, 8'h13, 3'b000, 1, 0, 0, "R2");
    vectors++; check("R2", "last on single beat", 32'(last_o), 1);
    idle(1'b1, "R2");
    // R2 R4: length 2 interleaved
    step(1, 8'h31, 3'b001, 1, 0, 1, "R2");
    idle(1'b1, "R2");
    idle(1'b1, "R2");
    // R7: full column crossing 0xFF
    step(1, 8'hFE, 3'b100, 1, 0, 0, "R7");
    idle(1'b1, "R7");
    idle(1'b1, "R7");
    vectors++; check("R7", "wrap to 0", 32'(col_o), 0);
    for (int i = 0; i < 300; i++) idle(1'b1, "R7");
    vectors++; check("R7", "still valid", 32'(valid_o), 1);
    // R8: terminate, and start beats terminate in the same cycle
    step(0, 0, 0, 0, 1, 1, "R8");
    step(1, 8'h80, 3'b011, 0, 1, 0, "R8");
    // R5: stall holds
    for (int i = 0; i < 3; i++) idle(1'b0, "R5");
    // R11: mode changes between starts are ignored
    for (int i = 0; i < 5; i++) step(0, 8'hFF, 3'b111, 1, 0, 1, "R11");
    // R9: restart mid burst
    step(1, 8'h07, 3'b011, 0, 0, 1, "R9");
    idle(1'b1, "R9");
    step(1, 8'hA2, 3'b010, 1, 0, 1, "R9");
    idle(1'b1, "R9");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit st, tm, ad, io;
      logic [2:0] lc;
      string tag;
      st = ($urandom_range(0, 15) == 0);
      tm = ($urandom_range(0, 39) == 0);
      ad = ($urandom_range(0, 9) < 7);
      io = $urandom_range(0, 1);
      lc = $urandom_range(0, 7);
      if (!m_act) tag = "R10";
      else if (m_lc[2]) tag = "R7";
      else if (m_io && m_lc[1:0] != 2'd0) tag = "R4";
      else tag = "R3";
      step(st, $urandom_range(0, 255), lc, io, tm, ad, tag);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule